// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Scheduler

This block owns the refresh duty for a 1M x 4 dynamic memory with multiplexed addressing. After reset it holds both strobes inactive for a programmable power-up pause (100 us at the intended clock). It then runs a fixed number of back-to-back initialization refresh cycles, eight by default, before it declares the memory ready for the access sequencer. From then on an interval timer marks a refresh as due every interval, about 15.6 us by default, so that 1024 rows are covered every 16 ms.

Due refreshes are counted in a small pending counter. The block asks the access sequencer for the strobes with `req`. It drives a refresh sequence only after `grant` is seen together with `req`. This lets refresh wait behind an open page. When the pending count reaches its ceiling, `urgent` tells the sequencer that refresh must now win over host traffic.

Two strobe orderings are offered, selected by `mode_sel`. In the CAS-before-RAS style the memory's own row counter is used. In the RAS-only style the block presents a 10-bit row from its own counter while CAS stays high. Phase lengths are given in clock cycles: strobe lead, RAS low time and precharge.

Top module: `dram_refresh_sched`

## Requirements
- R1: While `rst` is high, `ras_n` and `cas_n` are 1, and `addr_oe`, `req`, `busy`, `ready` and `urgent` are 0. `pend_cnt` is 0.
- R2: After reset is released, no strobe falls and `addr_oe` stays 0 for at least PAUSE_CYC cycles.
- R3: After the pause, exactly INIT_CYC refresh cycles run without any grant, and `req` stays 0 during them. `ready` rises on the clock edge that ends the last of them.
- R4: A cycle with `mode_sel`=0 (CAS-before-RAS) drives `cas_n` low CSR_CYC cycles before `ras_n` falls. `cas_n` stays low for the whole RAS-low time and rises on the same edge as `ras_n`. `addr_oe` stays 0.
- R5: In every refresh cycle `ras_n` stays low for exactly RAS_CYC cycles. It is followed by RP_CYC cycles with both strobes high before `busy` falls.
- R6: A cycle with `mode_sel`=1 (RAS-only) keeps `cas_n` high throughout. `addr_oe` is high from CSR_CYC cycles before `ras_n` falls until `ras_n` rises, with the row counter on `row_addr`.
- R7: The RAS-only row counter advances by one after each RAS-only cycle and wraps from 2^ROW_W-1 (1023) to 0.
- R8: Once `ready` is high, `pend_cnt` rises by one every INTERVAL_CYC cycles while no refresh completes.
- R9: `req` is high exactly when `ready` is high, `busy` is low and `pend_cnt` is nonzero. After `ready`, a refresh cycle starts only on an edge where `req` and `grant` are both high.
- R10: `pend_cnt` falls by one on the edge that completes a refresh. It saturates at PEND_MAX, where further due refreshes are dropped. `urgent` is high exactly when `pend_cnt` equals PEND_MAX.
- R11: `mode_sel` is sampled when a cycle starts. Changing it during a cycle does not alter that cycle's strobe ordering.
- R12: CAS-before-RAS cycles, including the initialization cycles, leave the RAS-only row counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Refresh style: 0 CAS-before-RAS, 1 RAS-only |
| grant | input | 1 | Access sequencer hands over the strobes |
| req | output | 1 | Refresh wanted and block idle |
| urgent | output | 1 | Pending count at its ceiling |
| busy | output | 1 | Refresh sequence in progress, strobes owned |
| ready | output | 1 | Power-up pause and init cycles complete |
| pend_cnt | output | $clog2(PEND_MAX+1) | Refreshes due but not yet done |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_oe | output | 1 | Drive `row_addr` onto the address bus |
| row_addr | output | ROW_W | RAS-only refresh row |

## Verification
The bench times each strobe phase in cycles and checks the exact lead of CAS over RAS. A design off by one in a phase counter would shorten RAS low time or precharge below the memory's minimum. It changes `mode_sel` partway through a CAS-before-RAS cycle. A design that used the live input would fall into a RAS-only ordering halfway through, with CAS low and the address driven together. It runs the pending count into saturation with no grant, and it checks that no strobe moves and the count does not wrap. It then drives more than 1024 RAS-only cycles, which would expose a row counter that skips, stalls after CAS-before-RAS cycles, or fails to wrap to row 0.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LEAD  = 2'd1,
    PH_LOW   = 2'd2,
    PH_PRECH = 2'd3
  } ref_phase_t;

  typedef enum logic {
    RM_CBR      = 1'b0,
    RM_RAS_ONLY = 1'b1
  } ref_mode_t;
endpackage

// File: rtl/ref_tick_timer.sv
module ref_tick_timer #(
  parameter int LIMIT = 3120
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (en) begin
        if (cnt == W'(LIMIT - 1)) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + W'(1);
        end
      end
    end
  end

  a_r8_tick_isolated: assert property (@(posedge clk) disable iff (rst)
    (LIMIT > 1 && tick) |=> !tick);
endmodule

// File: rtl/ref_debt_counter.sv
module ref_debt_counter #(
  parameter int MAX = 4,
  localparam int CW = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          full
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (inc && !dec && cnt != CW'(MAX)) begin
      cnt <= cnt + CW'(1);
    end else if (dec && !inc && cnt != '0) begin
      cnt <= cnt - CW'(1);
    end
  end

  assign full = (cnt == CW'(MAX));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(MAX));
  a_r10_step_down: assert property (@(posedge clk) disable iff (rst)
    (dec && !inc && cnt != '0) |=> cnt == $past(cnt) - CW'(1));
  a_r8_step_up: assert property (@(posedge clk) disable iff (rst)
    (inc && !dec && cnt != CW'(MAX)) |=> cnt == $past(cnt) + CW'(1));
endmodule

// File: rtl/ref_strobe_gen.sv
module ref_strobe_gen
  import dram_ref_pkg::*;
#(
  parameter int ROW_W   = 10,
  parameter int CSR_CYC = 2,
  parameter int RAS_CYC = 12,
  parameter int RP_CYC  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  ref_mode_t        mode,
  output logic             busy,
  output logic             done,
  output logic             ras_n,
  output logic             cas_n,
  output logic             addr_oe,
  output logic [ROW_W-1:0] row
);
  localparam int LONGEST = (RAS_CYC > RP_CYC)
                         ? ((RAS_CYC > CSR_CYC) ? RAS_CYC : CSR_CYC)
                         : ((RP_CYC > CSR_CYC) ? RP_CYC : CSR_CYC);
  localparam int PW = $clog2(LONGEST + 1);

  ref_phase_t   ph;
  ref_mode_t    mode_q;
  logic [PW-1:0] left;

  assign busy = (ph != PH_IDLE);
  assign done = (ph == PH_PRECH) && (left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      mode_q  <= RM_CBR;
      left    <= '0;
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      addr_oe <= 1'b0;
      row     <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph      <= PH_LEAD;
            mode_q  <= mode;
            left    <= PW'(CSR_CYC - 1);
            cas_n   <= (mode == RM_RAS_ONLY);
            addr_oe <= (mode == RM_RAS_ONLY);
          end
        end
        PH_LEAD: begin
          if (left == '0) begin
            ph    <= PH_LOW;
            left  <= PW'(RAS_CYC - 1);
            ras_n <= 1'b0;
          end else begin
            left <= left - PW'(1);
          end
        end
        PH_LOW: begin
          if (left == '0) begin
            ph      <= PH_PRECH;
            left    <= PW'(RP_CYC - 1);
            ras_n   <= 1'b1;
            cas_n   <= 1'b1;
            addr_oe <= 1'b0;
          end else begin
            left <= left - PW'(1);
          end
        end
        default: begin
          if (left == '0) begin
            ph <= PH_IDLE;
            if (mode_q == RM_RAS_ONLY) row <= row + ROW_W'(1);
          end else begin
            left <= left - PW'(1);
          end
        end
      endcase
    end
  end

  a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && mode_q == RM_CBR) |-> $past(!cas_n));
  a_r6_cas_held_high: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_q == RM_RAS_ONLY) |-> cas_n);
  a_r7_row_step: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == RM_RAS_ONLY) |=> row == $past(row) + ROW_W'(1));
  a_r12_row_kept: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == RM_CBR) |=> $stable(row));
  a_r11_mode_held: assert property (@(posedge clk) disable iff (rst)
    (busy && ph != PH_LEAD) |-> $stable(mode_q));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int PAUSE_CYC    = 20000,
  parameter int INTERVAL_CYC = 3120,
  parameter int INIT_CYC     = 8,
  parameter int PEND_MAX     = 4,
  parameter int CSR_CYC      = 2,
  parameter int RAS_CYC      = 12,
  parameter int RP_CYC       = 8,
  parameter int ROW_W        = 10,
  localparam int PCW = $clog2(PEND_MAX + 1),
  localparam int ICW = $clog2(INIT_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_sel,
  input  logic             grant,
  output logic             req,
  output logic             urgent,
  output logic             busy,
  output logic             ready,
  output logic [PCW-1:0]   pend_cnt,
  output logic             ras_n,
  output logic             cas_n,
  output logic             addr_oe,
  output logic [ROW_W-1:0] row_addr
);
  logic           pause_tick, pause_done;
  logic           due_tick;
  logic           start, done;
  logic [ICW-1:0] init_cnt;

  ref_tick_timer #(.LIMIT(PAUSE_CYC)) u_pause (
    .clk(clk), .rst(rst), .en(!pause_done), .tick(pause_tick));

  ref_tick_timer #(.LIMIT(INTERVAL_CYC)) u_interval (
    .clk(clk), .rst(rst), .en(ready), .tick(due_tick));

  ref_debt_counter #(.MAX(PEND_MAX)) u_debt (
    .clk(clk), .rst(rst), .inc(due_tick), .dec(done && ready),
    .cnt(pend_cnt), .full(urgent));

  ref_strobe_gen #(
    .ROW_W(ROW_W), .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
  ) u_strobe (
    .clk(clk), .rst(rst), .start(start), .mode(ref_mode_t'(mode_sel)),
    .busy(busy), .done(done), .ras_n(ras_n), .cas_n(cas_n),
    .addr_oe(addr_oe), .row(row_addr));

  always_ff @(posedge clk) begin
    if (rst) begin
      pause_done <= 1'b0;
      ready      <= 1'b0;
      init_cnt   <= '0;
    end else begin
      if (pause_tick) pause_done <= 1'b1;
      if (done && !ready) begin
        init_cnt <= init_cnt + ICW'(1);
        if (init_cnt == ICW'(INIT_CYC - 1)) ready <= 1'b1;
      end
    end
  end

  assign req   = ready && !busy && (pend_cnt != '0);
  assign start = !busy && ((pause_done && !ready) || (req && grant));

  a_r2_quiet_in_pause: assert property (@(posedge clk) disable iff (rst)
    !pause_done |-> (ras_n && cas_n && !addr_oe));
  a_r9_start_needs_grant: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && $past(ready)) |-> $past(grant));
  a_r3_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(ready) |-> ready);
  a_r10_urgent_only_full: assert property (@(posedge clk) disable iff (rst)
    urgent |-> pend_cnt != '0);
endmodule

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
  localparam int PAUSE    = 300;
  localparam int INTERVAL = 60;
  localparam int INIT     = 8;
  localparam int PMAX     = 4;
  localparam int CSR      = 2;
  localparam int RASC     = 12;
  localparam int RPC      = 8;
  localparam int RW       = 10;
  localparam int PCW      = $clog2(PMAX + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sel = 1'b0;
  logic grant = 1'b0;
  logic req, urgent, busy, ready, ras_n, cas_n, addr_oe;
  logic [PCW-1:0] pend_cnt;
  logic [RW-1:0]  row_addr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_refresh_sched #(
    .PAUSE_CYC(PAUSE), .INTERVAL_CYC(INTERVAL), .INIT_CYC(INIT),
    .PEND_MAX(PMAX), .CSR_CYC(CSR), .RAS_CYC(RASC), .RP_CYC(RPC), .ROW_W(RW)
  ) u_dram_refresh_sched (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .grant(grant), .req(req),
    .urgent(urgent), .busy(busy), .ready(ready), .pend_cnt(pend_cnt),
    .ras_n(ras_n), .cas_n(cas_n), .addr_oe(addr_oe), .row_addr(row_addr));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Follows one refresh cycle from its first visible strobe to busy falling.
  task automatic watch_cycle(input bit exp_ror, input bit flip, input int exp_row);
    int lead, low, pre;
    bit clean;
    while (cas_n && ras_n && !addr_oe) @(negedge clk);
    if (flip) mode_sel = ~mode_sel;
    clean = 1'b1;
    if (exp_ror) begin
      chk(cas_n && addr_oe, "R6 start: cas high, address driven", {cas_n, addr_oe}, 3);
      chk(row_addr == RW'(exp_row), "R7 row_addr", row_addr, exp_row);
    end else begin
      chk(!cas_n && !addr_oe, "R4 start: cas low, no address", {cas_n, addr_oe}, 0);
    end
    lead = 0;
    while (ras_n) begin
      @(negedge clk);
      lead++;
      if (exp_ror ? !(cas_n && addr_oe) : (cas_n || addr_oe)) clean = 1'b0;
    end
    chk(lead == CSR, exp_ror ? "R6 address lead before ras" : "R4 cas lead before ras", lead, CSR);
    low = 1;
    while (1) begin
      @(negedge clk);
      if (ras_n) break;
      low++;
      if (exp_ror ? !(cas_n && addr_oe) : (cas_n || addr_oe)) clean = 1'b0;
    end
    chk(clean, exp_ror ? "R6 cas high/address held" : "R4 R11 cas low/no address held", clean, 1);
    chk(low == RASC, "R5 ras low time", low, RASC);
    chk(cas_n && !addr_oe, "R4 R6 cas and address released with ras", {cas_n, addr_oe}, 2);
    pre = 0;
    while (busy) begin
      if (!(ras_n && cas_n)) clean = 1'b0;
      pre++;
      @(negedge clk);
    end
    chk(clean && pre == RPC, "R5 precharge length", pre, RPC);
  endtask

  task automatic t_reset_and_pause();
    int n;
    repeat (5) @(negedge clk);
    chk(ras_n && cas_n && !addr_oe && !req && !busy && !ready && !urgent && pend_cnt == 0,
        "R1 reset state", {ras_n, cas_n, addr_oe, req, busy, ready, urgent}, 7'b1100000);
    rst = 1'b0;
    n = 0;
    while (cas_n && ras_n && !addr_oe) begin
      @(negedge clk);
      n++;
    end
    chk(n >= PAUSE && n <= PAUSE + 3, "R2 power-up pause length", n, PAUSE);
  endtask

  task automatic t_init();
    bit req_seen;
    for (int i = 0; i < INIT; i++) begin
      req_seen = req;
      watch_cycle(1'b0, 1'b0, 0);
      if (i < INIT - 1) chk(!ready && !req && !req_seen, "R3 not ready during init", ready, 0);
    end
    chk(ready && pend_cnt == 0, "R3 ready after init cycles", ready, 1);
  endtask

  task automatic t_interval_and_debt();
    int t0, t1, t2;
    bit stay;
    t0 = cyc;
    while (pend_cnt != 1) @(negedge clk);
    t1 = cyc;
    chk(t1 - t0 >= INTERVAL && t1 - t0 <= INTERVAL + 2, "R8 first due", t1 - t0, INTERVAL);
    chk(req && !busy, "R9 req when due and idle", req, 1);
    while (pend_cnt != 2) @(negedge clk);
    t2 = cyc;
    chk(t2 - t1 == INTERVAL, "R8 interval", t2 - t1, INTERVAL);
    grant = 1'b1;
    @(negedge clk);
    chk(busy && !req, "R9 start on grant", {busy, req}, 2);
    grant = 1'b0;
    watch_cycle(1'b0, 1'b0, 0);
    chk(pend_cnt == 1, "R10 decrement on completion", pend_cnt, 1);
    while (pend_cnt != 3) @(negedge clk);
    chk(!urgent, "R10 urgent low below ceiling", urgent, 0);
    while (pend_cnt != PMAX) @(negedge clk);
    chk(urgent, "R10 urgent at ceiling", urgent, 1);
    stay = 1'b1;
    repeat (3 * INTERVAL) begin
      @(negedge clk);
      if (pend_cnt != PMAX || busy || !ras_n || !cas_n || !req) stay = 1'b0;
    end
    chk(stay, "R9 R10 saturated and waiting for grant", pend_cnt, PMAX);
  endtask

  task automatic t_mode_latch();
    grant = 1'b1;
    watch_cycle(1'b0, 1'b1, 0);
    chk(mode_sel == 1'b1, "R11 mode switched mid-cycle", mode_sel, 1);
  endtask

  task automatic t_ras_only_rows();
    for (int i = 0; i < 1026; i++) watch_cycle(1'b1, 1'b0, i % 1024);
    chk(row_addr == RW'(2), "R7 R12 row after wrap", row_addr, 2);
    grant = 1'b0;
  endtask

  initial begin
    t_reset_and_pause();
    t_init();
    t_interval_and_debt();
    t_mode_latch();
    t_ras_only_rows();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog expired actual=%0d expected<%0d", cyc, 180000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule